// File: doc/BRIEF.md
# Four-Channel Programmable Interval Timer Bank

This block holds four down-counting interval timers behind a small synchronous register port. The port has a 32-bit data path and a byte offset address. Timers 1 and 2 are 16 bits wide, and timers 3 and 4 are 32 bits wide. Each timer has the following per-timer controls and state:

- an enable bit;
- a 2-bit rate code that selects one of four tick rates;
- a load register, which supplies the start and reload value;
- a readable live count;
- a sticky interrupt output, cleared by a write to that timer's clear address.

The tick rates are single-cycle enable pulses. A free-running prescale counter on the base clock produces them at base/8, base/16, base/32 and base/64. With a 16 MHz base clock these rates are 2 MHz, 1 MHz, 500 kHz and 250 kHz. No derived clock exists.

Software loads a timer while it is stopped, which also places the value in the counter, and then sets the enable bit. A snapshot mode lets software read all four counts as they stood in one cycle. In this mode, a read of the combined timer 1/2 count word also captures timers 3 and 4. Later reads of the timer 3 and timer 4 count words return the captured values.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset every register is zero. All interrupts are low, all timers are stopped, and every readable address reads 0.
- R2: Rate code c (0..3) in a timer's control field selects a tick every 2^(3+c) base cycles. The tick is asserted in a cycle where the low 3+c bits of the base-cycle count since reset are all ones.
- R3: A timer whose enable bit is 0 keeps its count unchanged, except for the preload described in R7.
- R4: A timer's interrupt is set in the cycle after it expires. It stays set until any write to that timer's clear address. If an expiry and a clear fall in the same cycle, the set wins. Interrupt bit i belongs to timer i+1.
- R5: On a tick of its selected rate, an enabled timer whose count is above 1 decrements by exactly one.
- R6: On a tick, an enabled timer whose count is 0 or 1 reloads from its load register and expires. The reload uses the load register value from before any write in that cycle.
- R7: A write to a load register always updates it. If the timer is stopped, the same write also sets the counter to the value. If the timer is running, the counter keeps counting.
- R8: Timers 1 and 2 keep only data bits [15:0] of a load write. Timers 3 and 4 keep all 32 bits.
- R9: A read returns its data in `rdata` on the clock edge that samples `rd_en`, and `rdata` holds while `rd_en` is low. With snapshot mode off, every count read returns the live count of that cycle.
- R10: With snapshot mode on, a read of the combined count word 0x1C also captures the counts of timers 3 and 4 in that cycle. Reads of 0x20 and 0x24 then return the captured values until the next such read.
- R11: The register map and control word are laid out as follows:
  - Byte offsets:
    - 0x00 control;
    - 0x0C, 0x10, 0x14, 0x18 load registers of timers 1 to 4;
    - 0x1C combined count word, with timer 2 in [31:16] and timer 1 in [15:0];
    - 0x20 and 0x24 counts of timers 3 and 4;
    - 0x30, 0x34, 0x38, 0x3C interrupt clears of timers 1 to 4.
  - Control word fields: timer n uses bits [4(n-1)+1 : 4(n-1)] as its rate code and bit 4(n-1)+2 as its enable. Bit 16 is snapshot mode.
  - Unused control bits read 0. Load registers read back. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (16 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-timer sticky interrupt, bit i for timer i+1 |

## Verification
The bench targets the following corner cases:
- **Snapshot mode.** It reads the timer 3 and 4 count words both before and after a fresh capture. A design that latched on every read, or never latched, would return live counts where frozen ones are expected.
- **Load writes to a running timer.** It writes a load register while the timer runs, and writes oversized data to the 16-bit timers. A design that restarted the counter, or kept the upper bits, would show a jump in the combined count word.
- **Stopped timers and interrupt clears.** It clears interrupts and stops timers, then reads the same count twice, far apart. Any drift, or an interrupt that never rises or never falls, shows up directly.
- **Reset in the middle of a run.** It resets the block mid-run to confirm that every register returns to zero.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = 16;
  localparam int ADDR_W     = 6;
  localparam int NUM_TMR    = 4;
  localparam int NUM_NARROW = 2;
  localparam int RATE_W     = 2;
  localparam int NUM_RATE   = 1 << RATE_W;
  localparam int BASE_SHIFT = 3;
  localparam int FIELD_W    = 4;
  localparam int EN_BIT     = 2;
  localparam int SNAP_BIT   = 16;
  localparam int REG_STEP   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_LOAD0 = 6'h0C;
  localparam logic [ADDR_W-1:0] A_CNT12 = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CNT3  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CNT4  = 6'h24;
  localparam logic [ADDR_W-1:0] A_CLR0  = 6'h30;

  function automatic int tmr_width(int idx);
    return (idx < NUM_NARROW) ? HALF_W : DATA_W;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_TMR; i++) m[FIELD_W*i +: EN_BIT+1] = '1;
    m[SNAP_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
  parameter int BASE_SHIFT = 3,
  parameter int NUM_RATE   = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_RATE-1:0] tick_o
);
  localparam int CNT_W = BASE_SHIFT + NUM_RATE - 1;

  logic [CNT_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_RATE; k++) begin : g_tick
    assign tick_o[k] = &base_q[BASE_SHIFT+k-1:0];
  end

  // R2: a slower tick always coincides with the fastest one
  p_tick_nest_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o[NUM_RATE-1] |-> tick_o[0]);
  // R2: fastest tick is a single-cycle pulse
  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
  parameter int W        = 16,
  parameter int RATE_W   = 2,
  parameter int NUM_RATE = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [NUM_RATE-1:0] tick_i,
  input  logic                load_wr_i,
  input  logic [W-1:0]        load_val_i,
  input  logic                clr_i,
  output logic [W-1:0]        count_o,
  output logic [W-1:0]        load_o,
  output logic                irq_o
);
  logic [W-1:0] load_q, count_q;
  logic         irq_q, step, expire;

  assign step   = en_i & tick_i[rate_i];
  assign expire = step & (count_q <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (load_wr_i) load_q <= load_val_i;
      if (!en_i) begin
        if (load_wr_i) count_q <= load_val_i;
      end else if (step) begin
        count_q <= expire ? load_q : count_q - 1'b1;
      end
      if (expire)     irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign count_o = count_q;
  assign load_o  = load_q;
  assign irq_o   = irq_q;

  p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_wr_i) |=> $stable(count_o));
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i[rate_i] && count_o > W'(1)) |=> count_o == $past(count_o) - 1'b1);
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i[rate_i] && count_o <= W'(1)) |=> count_o == $past(load_o));
  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && tick_i[rate_i] && count_o <= W'(1)) |=> irq_o);
  p_irq_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

  logic [DATA_W-1:0]   ctrl_q, rdata_q, rd_mux;
  logic [DATA_W-1:0]   snap_q [NUM_NARROW];
  logic [DATA_W-1:0]   cnt_all [NUM_TMR];
  logic [DATA_W-1:0]   load_all [NUM_TMR];
  logic [NUM_TMR-1:0]  load_wr, clr_wr;
  logic [NUM_RATE-1:0] tick;
  logic                snap_mode, snap_take;

  tmr_prescale #(.BASE_SHIFT(BASE_SHIFT), .NUM_RATE(NUM_RATE)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int CW = tmr_width(i);
    logic [CW-1:0] cnt_w, load_w;

    assign load_wr[i] = wr_en && (addr == A_LOAD0 + ADDR_W'(REG_STEP*i));
    assign clr_wr[i]  = wr_en && (addr == A_CLR0 + ADDR_W'(REG_STEP*i));

    tmr_channel #(.W(CW), .RATE_W(RATE_W), .NUM_RATE(NUM_RATE)) u_ch (
      .clk(clk), .rst(rst),
      .en_i(ctrl_q[FIELD_W*i + EN_BIT]),
      .rate_i(ctrl_q[FIELD_W*i +: RATE_W]),
      .tick_i(tick),
      .load_wr_i(load_wr[i]),
      .load_val_i(wdata[CW-1:0]),
      .clr_i(clr_wr[i]),
      .count_o(cnt_w),
      .load_o(load_w),
      .irq_o(irq[i]));

    assign cnt_all[i]  = DATA_W'(cnt_w);
    assign load_all[i] = DATA_W'(load_w);
  end

  assign snap_mode = ctrl_q[SNAP_BIT];
  assign snap_take = rd_en && (addr == A_CNT12) && snap_mode;

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL)  rd_mux = ctrl_q;
    if (addr == A_CNT12) rd_mux = {cnt_all[1][HALF_W-1:0], cnt_all[0][HALF_W-1:0]};
    if (addr == A_CNT3)  rd_mux = snap_mode ? snap_q[0] : cnt_all[2];
    if (addr == A_CNT4)  rd_mux = snap_mode ? snap_q[1] : cnt_all[3];
    for (int i = 0; i < NUM_TMR; i++)
      if (addr == A_LOAD0 + ADDR_W'(REG_STEP*i)) rd_mux = load_all[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
      for (int j = 0; j < NUM_NARROW; j++) snap_q[j] <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata & CTRL_MASK;
      if (rd_en) rdata_q <= rd_mux;
      if (snap_take)
        for (int j = 0; j < NUM_NARROW; j++) snap_q[j] <= cnt_all[NUM_NARROW + j];
    end
  end

  assign rdata = rdata_q;

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_snap_take_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CNT12 && ctrl_q[SNAP_BIT]) |=> snap_q[0] == $past(cnt_all[2]));
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == A_CNT12) |=> $stable(snap_q[1]));
  p_ctrl_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam int VEC_W      = 62;
  localparam int NVEC       = 42;
  // op: 0 wait, 1 write, 2 read; fields {op, addr, data, wait, req}
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {2'd2, 8'h00, 32'h0,         16'd0,   4'd1},  // R1 control reads 0
    {2'd1, 8'h0C, 32'h5,         16'd0,   4'd7},  // R7 preload T1
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd7},
    {2'd1, 8'h10, 32'h0001_0003, 16'd0,   4'd8},  // R8 upper bits dropped
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd8},
    {2'd1, 8'h14, 32'h100,       16'd0,   4'd7},
    {2'd1, 8'h18, 32'hFFFF_FFF0, 16'd0,   4'd8},
    {2'd2, 8'h18, 32'h0,         16'd0,   4'd11}, // R11 load readback
    {2'd1, 8'h00, 32'h0000_2754, 16'd40,  4'd3},
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd5},  // R5 countdown
    {2'd2, 8'h20, 32'h0,         16'd0,   4'd5},
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd3},  // R3 T4 stopped
    {2'd0, 8'h00, 32'h0,         16'd120, 4'd6},
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd6},  // R6 reload
    {2'd1, 8'h30, 32'h0,         16'd0,   4'd4},  // R4 clear T1
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd4},
    {2'd1, 8'h00, 32'h0001_2754, 16'd0,   4'd10}, // R10 snapshot on
    {2'd2, 8'h1C, 32'h0,         16'd60,  4'd10},
    {2'd2, 8'h20, 32'h0,         16'd0,   4'd10},
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd10},
    {2'd1, 8'h00, 32'h0001_6754, 16'd100, 4'd2},  // R2 T4 at rate 2
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd10},
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd10},
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd10},
    {2'd1, 8'h0C, 32'h2,         16'd150, 4'd7},  // R7 load while running
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd7},
    {2'd1, 8'h00, 32'h0000_6754, 16'd0,   4'd9},  // R9 live reads
    {2'd2, 8'h20, 32'h0,         16'd0,   4'd9},
    {2'd2, 8'h20, 32'h0,         16'd30,  4'd9},
    {2'd2, 8'h20, 32'h0,         16'd0,   4'd9},
    {2'd1, 8'h00, 32'h0,         16'd30,  4'd3},
    {2'd2, 8'h1C, 32'h0,         16'd64,  4'd3},
    {2'd2, 8'h1C, 32'h0,         16'd0,   4'd3},
    {2'd1, 8'h34, 32'h0,         16'd0,   4'd4},
    {2'd1, 8'h38, 32'h0,         16'd0,   4'd4},
    {2'd1, 8'h3C, 32'h0,         16'd0,   4'd4},
    {2'd2, 8'h04, 32'h0,         16'd0,   4'd11},
    {2'd1, 8'h00, 32'hFFFF_FFFF, 16'd0,   4'd11},
    {2'd2, 8'h00, 32'h0,         16'd200, 4'd11},
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd2},
    {2'd1, 8'h00, 32'h0,         16'd0,   4'd2},
    {2'd2, 8'h24, 32'h0,         16'd0,   4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  tmr_bank dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // requirement model
  logic [5:0]  m_pre;
  logic [31:0] m_ctrl, m_rdata;
  logic [31:0] m_load [4];
  logic [31:0] m_cnt [4];
  logic [31:0] m_snap [2];
  logic [3:0]  m_irq;

  function automatic logic [31:0] msk(int i);
    return (i < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [5:0] a);
    case (a)
      6'h00: return m_ctrl;
      6'h0C: return m_load[0];
      6'h10: return m_load[1];
      6'h14: return m_load[2];
      6'h18: return m_load[3];
      6'h1C: return {m_cnt[1][15:0], m_cnt[0][15:0]};
      6'h20: return m_ctrl[16] ? m_snap[0] : m_cnt[2];
      6'h24: return m_ctrl[16] ? m_snap[1] : m_cnt[3];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = '0; m_ctrl = '0; m_rdata = '0; m_irq = '0;
      for (int i = 0; i < 4; i++) begin m_load[i] = '0; m_cnt[i] = '0; end
      m_snap[0] = '0; m_snap[1] = '0;
    end else begin
      if (rd_en) begin
        m_rdata = model_read(addr);
        if (addr == 6'h1C && m_ctrl[16]) begin m_snap[0] = m_cnt[2]; m_snap[1] = m_cnt[3]; end
      end
      for (int i = 0; i < 4; i++) begin
        int span;
        bit en, tk, lw, cw, ex;
        en   = m_ctrl[4*i+2];
        span = (8 << m_ctrl[4*i +: 2]) - 1;
        tk   = ((32'(m_pre) & span) == span);
        lw   = wr_en && (addr == 6'(12 + 4*i));
        cw   = wr_en && (addr == 6'(48 + 4*i));
        ex   = 1'b0;
        if (!en) begin
          if (lw) m_cnt[i] = wdata & msk(i);
        end else if (tk) begin
          if (m_cnt[i] <= 1) begin m_cnt[i] = m_load[i]; ex = 1'b1; end
          else m_cnt[i] = m_cnt[i] - 1;
        end
        if (lw) m_load[i] = wdata & msk(i);
        if (ex) m_irq[i] = 1'b1;
        else if (cw) m_irq[i] = 1'b0;
      end
      if (wr_en && addr == 6'h00) m_ctrl = wdata & 32'h0001_7777;
      m_pre = m_pre + 1'b1;
    end
  end

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, input int rq);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(rq, rdata, m_rdata);
    chk(4, {28'h0, irq}, {28'h0, m_irq});  // R4 interrupt lines track model
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
      summary();
    end
  end

  initial begin
    logic [31:0] first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(1, {28'h0, irq}, 32'h0);  // R1 irq low after reset
    for (int v = 0; v < NVEC; v++) begin
      logic [VEC_W-1:0] e;
      e = VEC[v];
      case (e[61:60])
        2'd1: do_write(e[57:52], e[51:20]);
        2'd2: do_read(e[57:52], int'(e[3:0]));
        default: ;
      endcase
      repeat (int'(e[19:4])) @(negedge clk);
    end

    // R1: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    chk(1, {28'h0, irq}, 32'h0);
    do_read(6'h00, 1); chk(1, rdata, 32'h0);
    do_read(6'h1C, 1); chk(1, rdata, 32'h0);
    do_read(6'h18, 1); chk(1, rdata, 32'h0);

    // R7: preload while stopped shows immediately
    do_write(6'h14, 32'h1234_5678);
    do_read(6'h20, 7); chk(7, rdata, 32'h1234_5678);
    // R8: narrow timer keeps only low half
    do_write(6'h0C, 32'hABCD_0042);
    do_read(6'h1C, 8); chk(8, rdata, 32'h0000_0042);

    // R3: stopped timer does not drift
    do_read(6'h20, 3); first = rdata;
    repeat (100) @(negedge clk);
    do_read(6'h20, 3); chk(3, rdata, first);

    // R4/R6: load 0 expires on every tick; clear after stopping
    do_write(6'h0C, 32'h0);
    do_write(6'h00, 32'h0000_0004);
    repeat (20) @(negedge clk);
    chk(4, {31'h0, irq[0]}, 32'h1);
    do_write(6'h00, 32'h0);
    do_write(6'h30, 32'h0);
    chk(4, {31'h0, irq[0]}, 32'h0);
    repeat (20) @(negedge clk);
    chk(4, {31'h0, irq[0]}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule